// File: doc/BRIEF.md
# HMAC Control and Key Register Guard

This block is the register-side controller of a keyed-hash accelerator. It holds a four-bit configuration word, eight 32-bit secret key words and an eight-word digest. A single write/read strobe bus reaches all of them. Start and process commands drive a small state machine, and a handshake (start pulse, process pulse, done pulse with a 256-bit digest) links that machine to an external hash core. The hash rounds themselves, the message FIFO and bus integrity checking live outside this block. The block only sees the FIFO's empty level.

The state machine has four named states:
- `ST_IDLE` (code 0): the only state in which configuration and key writes are accepted.
- `ST_ABSORB` (code 1): message data is flowing into the core.
- `ST_FINISH` (code 2): waiting for the core's done pulse.
- `ST_DONE` (code 3): lasts one cycle after the digest is captured.

Its transitions are:
- IDLE→ABSORB on a start command while SHA is enabled.
- ABSORB→FINISH on a process command.
- FINISH→DONE on `core_done`.
- DONE→IDLE unconditionally.

Any command that breaks this order is dropped. It records an error code and raises the error interrupt. A configuration write outside IDLE is dropped silently. A key write outside IDLE is dropped and reported.

Top module: `hkey_ctrl`

## Requirements
- R1: After reset the configuration, error code, interrupt flags, digest and read data are all zero, the state is `ST_IDLE`, and no start or process pulse is issued.
- R2: Word address 0x00 is the configuration register. Its bits are: bit 0 HMAC enable (`core_hmac_en`), bit 1 SHA enable, bit 2 message endian swap (`core_endian_swap`), bit 3 digest byte swap. Bits 31:4 are ignored on write and read as 0.
- R3: A configuration write outside `ST_IDLE` leaves the configuration unchanged and sets no error code.
- R4: Key word i is written at address 0x08+i and reads back as 0. `core_key` equals {K0,K1,...,K7}, with K0 in bits 255:224. A key write outside `ST_IDLE` leaves the key unchanged, sets error code 1 and raises the error interrupt.
- R5: Address 0x01 is the command register: bit 0 is start, bit 1 is process, and start takes priority when both are written. It always reads as 0. A start in `ST_IDLE` with SHA enabled enters `ST_ABSORB` and drives `core_start` high for exactly the one cycle after the write. Address 0x02 reads the state code in bits 1:0 and the `fifo_empty` level in bit 4.
- R6: A process command in `ST_ABSORB` enters `ST_FINISH` and drives `core_process` high for the one cycle after the write. A process command in any other state sets error code 3 and leaves the state unchanged.
- R7: A start command outside `ST_IDLE` sets error code 2. A start command in `ST_IDLE` with SHA disabled sets error code 4. In both cases the state is left unchanged.
- R8: `core_done` in `ST_FINISH` captures `core_digest`, enters `ST_DONE` for one cycle and then returns to `ST_IDLE`. `core_done` in any other state is ignored.
- R9: Digest word i reads at address 0x10+i as `core_digest[255-32i -: 32]`. When digest swap is set, the four bytes within each word are reversed and the word order is unchanged.
- R10: An accepted configuration write with SHA enable at 0 clears the stored digest to zero.
- R11: Address 0x04 holds sticky interrupt flags: bit 0 done, bit 1 FIFO empty, bit 2 error. Writing 1 to a bit clears it. A flag being set in the same cycle as its clear wins. The FIFO flag sets on a rising edge of `fifo_empty`. The flags drive `intr_done`, `intr_fifo_empty` and `intr_err`.
- R12: Address 0x03 returns the most recent error code (0 if none has occurred).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; data appears on `reg_rdata` after the next edge |
| reg_addr | input | 5 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| core_start | output | 1 | One-cycle start pulse to the hash core |
| core_process | output | 1 | One-cycle finish-message pulse to the hash core |
| core_hmac_en | output | 1 | Keyed mode enable for the core |
| core_endian_swap | output | 1 | Message byte order select for the core |
| core_key | output | 256 | Secret key, word 0 most significant |
| core_done | input | 1 | Core completion pulse |
| core_digest | input | 256 | Digest from the core, word 0 most significant |
| fifo_empty | input | 1 | Message FIFO empty level |
| intr_done | output | 1 | Done interrupt |
| intr_fifo_empty | output | 1 | FIFO-empty interrupt |
| intr_err | output | 1 | Error interrupt |

## Verification
The bench targets writes that land while the engine is busy. A design that let a configuration or key write through would show a changed configuration readback or a changed `core_key` word. It also tries out-of-order commands: process while idle, start while absorbing, start with SHA disabled. A design that got these wrong would move state or report the wrong error code. The bench checks that a done pulse outside `ST_FINISH` is ignored, that a FIFO-empty edge arriving in the same cycle as its own clear keeps the flag set, and that digest byte reversal changes byte order but not word order. A wrong byte reversal shows up as a mismatched byte pattern in a known digest word.

// File: rtl/hkc_pkg.sv
package hkc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ABSORB = 2'd1,
        ST_FINISH = 2'd2,
        ST_DONE   = 2'd3
    } hkc_state_e;

    typedef enum logic [2:0] {
        ERR_NONE       = 3'd0,
        ERR_KEY_BUSY   = 3'd1,
        ERR_START_BUSY = 3'd2,
        ERR_PROC_ORDER = 3'd3,
        ERR_START_OFF  = 3'd4
    } hkc_err_e;

    localparam int unsigned ADDR_W = 5;
    localparam int unsigned CFG_W  = 4;
    localparam int unsigned IRQ_W  = 3;

    localparam logic [ADDR_W-1:0] A_CFG  = 5'h00;
    localparam logic [ADDR_W-1:0] A_CMD  = 5'h01;
    localparam logic [ADDR_W-1:0] A_STAT = 5'h02;
    localparam logic [ADDR_W-1:0] A_ERR  = 5'h03;
    localparam logic [ADDR_W-1:0] A_INTR = 5'h04;
    localparam logic [ADDR_W-1:0] A_KEY  = 5'h08;
    localparam logic [ADDR_W-1:0] A_DIG  = 5'h10;

    localparam int unsigned CFG_HMAC   = 0;
    localparam int unsigned CFG_SHA    = 1;
    localparam int unsigned CFG_ENDIAN = 2;
    localparam int unsigned CFG_DSWAP  = 3;

    localparam int unsigned IRQ_DONE = 0;
    localparam int unsigned IRQ_FIFO = 1;
    localparam int unsigned IRQ_ERR  = 2;

    function automatic logic [31:0] bswap32(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

endpackage

// File: rtl/hkc_fsm.sv
module hkc_fsm
    import hkc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_start,
    input  logic       cmd_proc,
    input  logic       sha_en,
    input  logic       key_wr,
    input  logic       core_done,
    output hkc_state_e state_o,
    output logic       core_start_o,
    output logic       core_process_o,
    output logic       digest_cap_o,
    output logic       err_valid_o,
    output hkc_err_e   err_code_o
);

    hkc_state_e state_q, state_d;
    hkc_err_e   err_d, err_q;
    logic       start_q, proc_q;

    // Next state and error decode
    always_comb begin
        state_d = state_q;
        err_d   = ERR_NONE;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_start) begin
                    if (sha_en) state_d = ST_ABSORB;
                    else        err_d   = ERR_START_OFF;
                end else if (cmd_proc) begin
                    err_d = ERR_PROC_ORDER;
                end
            end
            ST_ABSORB: begin
                if (cmd_start)     err_d   = ERR_START_BUSY;
                else if (cmd_proc) state_d = ST_FINISH;
            end
            ST_FINISH: begin
                if (core_done)     state_d = ST_DONE;
                if (cmd_start)     err_d   = ERR_START_BUSY;
                else if (cmd_proc) err_d   = ERR_PROC_ORDER;
            end
            ST_DONE: begin
                state_d = ST_IDLE;
                if (cmd_start)     err_d = ERR_START_BUSY;
                else if (cmd_proc) err_d = ERR_PROC_ORDER;
            end
            default: state_d = ST_IDLE;
        endcase
        if (key_wr && (state_q != ST_IDLE)) err_d = ERR_KEY_BUSY;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q <= 1'b0;
            proc_q  <= 1'b0;
            err_q   <= ERR_NONE;
        end else begin
            start_q <= (state_q == ST_IDLE)   && (state_d == ST_ABSORB);
            proc_q  <= (state_q == ST_ABSORB) && (state_d == ST_FINISH);
            if (err_d != ERR_NONE) err_q <= err_d;
        end
    end

    assign state_o        = state_q;
    assign core_start_o   = start_q;
    assign core_process_o = proc_q;
    assign digest_cap_o   = (state_q == ST_FINISH) && core_done;
    assign err_valid_o    = (err_d != ERR_NONE);
    assign err_code_o     = err_q;

    a_r5_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        core_start_o |=> !core_start_o);
    a_r5_start_in_absorb: assert property (@(posedge clk) disable iff (!rst_n)
        core_start_o |-> state_q == ST_ABSORB);
    a_r6_proc_in_finish: assert property (@(posedge clk) disable iff (!rst_n)
        core_process_o |-> state_q == ST_FINISH);
    a_r8_done_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_DONE |=> state_q == ST_IDLE);
    a_r12_err_latched: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid_o |=> err_code_o == $past(err_d));

endmodule

// File: rtl/hkc_regs.sv
module hkc_regs
    import hkc_pkg::*;
#(
    parameter int unsigned NUM_WORDS = 8,
    parameter int unsigned WORD_W    = 32,
    localparam int unsigned IDX_W    = $clog2(NUM_WORDS),
    localparam int unsigned DIG_W    = NUM_WORDS * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idle,
    input  logic              cfg_wr,
    input  logic              key_wr,
    input  logic [IDX_W-1:0]  key_idx,
    input  logic [WORD_W-1:0] wdata,
    input  logic              digest_cap,
    input  logic [DIG_W-1:0]  core_digest,
    output logic [CFG_W-1:0]  cfg_o,
    output logic [DIG_W-1:0]  key_o,
    output logic [DIG_W-1:0]  digest_o
);

    logic [CFG_W-1:0] cfg_q;
    logic [DIG_W-1:0] digest_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cfg_q <= '0;
        else if (cfg_wr && idle) cfg_q <= wdata[CFG_W-1:0];
    end

    for (genvar i = 0; i < NUM_WORDS; i++) begin : g_key
        logic [WORD_W-1:0] word_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                word_q <= '0;
            else if (key_wr && idle && (key_idx == IDX_W'(i)))
                word_q <= wdata;
        end
        assign key_o[(NUM_WORDS-1-i)*WORD_W +: WORD_W] = word_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            digest_q <= '0;
        else if (digest_cap)
            digest_q <= core_digest;
        else if (cfg_wr && idle && !wdata[CFG_SHA])
            digest_q <= '0;
    end

    assign cfg_o    = cfg_q;
    assign digest_o = digest_q;

    a_r3_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !idle |=> $stable(cfg_q));
    a_r4_key_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !idle |=> $stable(key_o));
    a_r10_digest_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && idle && !wdata[CFG_SHA]) |=> digest_q == '0);

endmodule

// File: rtl/hkc_irq.sv
module hkc_irq
    import hkc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             done_set,
    input  logic             err_set,
    input  logic             fifo_lvl,
    input  logic             clr_wr,
    input  logic [IRQ_W-1:0] clr_mask,
    output logic [IRQ_W-1:0] intr_o
);

    logic             fifo_prev_q;
    logic [IRQ_W-1:0] intr_q, set_v, clr_v;

    always_comb begin
        set_v           = '0;
        set_v[IRQ_DONE] = done_set;
        set_v[IRQ_ERR]  = err_set;
        set_v[IRQ_FIFO] = fifo_lvl && !fifo_prev_q;
        clr_v           = clr_wr ? clr_mask : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            intr_q      <= '0;
            fifo_prev_q <= 1'b1;
        end else begin
            intr_q      <= (intr_q & ~clr_v) | set_v;
            fifo_prev_q <= fifo_lvl;
        end
    end

    assign intr_o = intr_q;

    a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_v) |=> ((intr_q & $past(set_v)) == $past(set_v)));
    a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_wr && (|intr_q)) |=> ((intr_q & $past(intr_q)) == $past(intr_q)));

endmodule

// File: rtl/hkey_ctrl.sv
module hkey_ctrl
    import hkc_pkg::*;
#(
    parameter int unsigned NUM_WORDS = 8,
    parameter int unsigned WORD_W    = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        reg_wr,
    input  logic                        reg_rd,
    input  logic [4:0]                  reg_addr,
    input  logic [31:0]                 reg_wdata,
    output logic [31:0]                 reg_rdata,
    output logic                        core_start,
    output logic                        core_process,
    output logic                        core_hmac_en,
    output logic                        core_endian_swap,
    output logic [NUM_WORDS*WORD_W-1:0] core_key,
    input  logic                        core_done,
    input  logic [NUM_WORDS*WORD_W-1:0] core_digest,
    input  logic                        fifo_empty,
    output logic                        intr_done,
    output logic                        intr_fifo_empty,
    output logic                        intr_err
);

    localparam int unsigned IDX_W = $clog2(NUM_WORDS);
    localparam int unsigned DIG_W = NUM_WORDS * WORD_W;

    hkc_state_e       state;
    hkc_err_e         err_code;
    logic             cfg_wr, key_wr, cmd_start, cmd_proc, intr_wr;
    logic             digest_cap, err_valid;
    logic [CFG_W-1:0] cfg;
    logic [DIG_W-1:0] digest, dig_view;
    logic [IRQ_W-1:0] intr;
    logic [31:0]      rd_d;

    // Write decode
    always_comb begin
        cfg_wr    = reg_wr && (reg_addr == A_CFG);
        intr_wr   = reg_wr && (reg_addr == A_INTR);
        cmd_start = reg_wr && (reg_addr == A_CMD) && reg_wdata[0];
        cmd_proc  = reg_wr && (reg_addr == A_CMD) && reg_wdata[1] && !reg_wdata[0];
        key_wr    = reg_wr && (reg_addr >= A_KEY)
                           && (reg_addr < ADDR_W'(A_KEY + NUM_WORDS));
    end

    hkc_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .cmd_start      (cmd_start),
        .cmd_proc       (cmd_proc),
        .sha_en         (cfg[CFG_SHA]),
        .key_wr         (key_wr),
        .core_done      (core_done),
        .state_o        (state),
        .core_start_o   (core_start),
        .core_process_o (core_process),
        .digest_cap_o   (digest_cap),
        .err_valid_o    (err_valid),
        .err_code_o     (err_code)
    );

    hkc_regs #(.NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .idle        (state == ST_IDLE),
        .cfg_wr      (cfg_wr),
        .key_wr      (key_wr),
        .key_idx     (reg_addr[IDX_W-1:0]),
        .wdata       (reg_wdata),
        .digest_cap  (digest_cap),
        .core_digest (core_digest),
        .cfg_o       (cfg),
        .key_o       (core_key),
        .digest_o    (digest)
    );

    hkc_irq u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .done_set (digest_cap),
        .err_set  (err_valid),
        .fifo_lvl (fifo_empty),
        .clr_wr   (intr_wr),
        .clr_mask (reg_wdata[IRQ_W-1:0]),
        .intr_o   (intr)
    );

    // Digest view: word i taken from the top, bytes optionally reversed
    for (genvar i = 0; i < NUM_WORDS; i++) begin : g_view
        logic [WORD_W-1:0] raw;
        assign raw = digest[(NUM_WORDS-1-i)*WORD_W +: WORD_W];
        assign dig_view[i*WORD_W +: WORD_W] = cfg[CFG_DSWAP] ? bswap32(raw) : raw;
    end

    // Read mux
    always_comb begin
        rd_d = '0;
        if (reg_addr == A_CFG) begin
            rd_d[CFG_W-1:0] = cfg;
        end else if (reg_addr == A_STAT) begin
            rd_d[1:0] = state;
            rd_d[4]   = fifo_empty;
        end else if (reg_addr == A_ERR) begin
            rd_d[2:0] = err_code;
        end else if (reg_addr == A_INTR) begin
            rd_d[IRQ_W-1:0] = intr;
        end
        for (int i = 0; i < NUM_WORDS; i++) begin
            if (reg_addr == ADDR_W'(A_DIG + i)) rd_d = dig_view[i*WORD_W +: WORD_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      reg_rdata <= '0;
        else if (reg_rd) reg_rdata <= rd_d;
    end

    assign core_hmac_en     = cfg[CFG_HMAC];
    assign core_endian_swap = cfg[CFG_ENDIAN];
    assign intr_done        = intr[IRQ_DONE];
    assign intr_fifo_empty  = intr[IRQ_FIFO];
    assign intr_err         = intr[IRQ_ERR];

    a_r5_cmd_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == A_CMD) |=> reg_rdata == '0);
    a_r4_key_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && key_wr) |=> reg_rdata == '0);

endmodule

// File: tb/hkey_ctrl_tb.sv
module hkey_ctrl_tb_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_wr = 1'b0, reg_rd = 1'b0;
    logic [4:0]   reg_addr = '0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic         core_start, core_process, core_hmac_en, core_endian_swap;
    logic [255:0] core_key;
    logic         core_done = 1'b0;
    logic [255:0] core_digest = '0;
    logic         fifo_empty = 1'b1;
    logic         intr_done, intr_fifo_empty, intr_err;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    hkey_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .core_start(core_start), .core_process(core_process),
        .core_hmac_en(core_hmac_en), .core_endian_swap(core_endian_swap),
        .core_key(core_key), .core_done(core_done), .core_digest(core_digest),
        .fifo_empty(fifo_empty), .intr_done(intr_done),
        .intr_fifo_empty(intr_fifo_empty), .intr_err(intr_err)
    );

    typedef struct packed {
        logic [1:0]  op;    // 0 write, 1 read and compare, 2 compare key word
        logic [4:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VT [NV] = '{
        '{2'd0, 5'h00, 32'h0000_00F3, 32'h0, 4'd2},
        '{2'd1, 5'h00, 32'h0,         32'h3, 4'd2},
        '{2'd0, 5'h00, 32'h0000_000F, 32'h0, 4'd2},
        '{2'd1, 5'h00, 32'h0,         32'hF, 4'd2},
        '{2'd0, 5'h08, 32'hCAFE_0000, 32'h0, 4'd4},
        '{2'd0, 5'h0F, 32'hCAFE_0007, 32'h0, 4'd4},
        '{2'd0, 5'h0B, 32'h1234_5678, 32'h0, 4'd4},
        '{2'd2, 5'd0,  32'h0, 32'hCAFE_0000, 4'd4},
        '{2'd2, 5'd7,  32'h0, 32'hCAFE_0007, 4'd4},
        '{2'd2, 5'd3,  32'h0, 32'h1234_5678, 4'd4},
        '{2'd1, 5'h08, 32'h0,         32'h0, 4'd4},
        '{2'd0, 5'h01, 32'h0,         32'h0, 4'd5},
        '{2'd1, 5'h01, 32'h0,         32'h0, 4'd5},
        '{2'd1, 5'h03, 32'h0,         32'h0, 4'd12},
        '{2'd1, 5'h02, 32'h0,         32'h10, 4'd5}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    function automatic logic [31:0] key_word(input int idx);
        return core_key[255-32*idx -: 32];
    endfunction

    function automatic logic [31:0] dword(input int i);
        return {8'(i), 8'hA5, 8'h5A, 8'(8'h10 + i)};
    endfunction

    function automatic logic [31:0] swp(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 intr", {29'b0, intr_err, intr_fifo_empty, intr_done}, 32'h0);
        chk("R1 pulses", {30'b0, core_start, core_process}, 32'h0);
        chk("R1 rdata", reg_rdata, 32'h0);
        rd(5'h00, v); chk("R1 cfg", v, 32'h0);
        rd(5'h02, v); chk("R1 status", v, 32'h10);
        rd(5'h10, v); chk("R1 digest", v, 32'h0);

        // Vector table
        for (int k = 0; k < NV; k++) begin
            case (VT[k].op)
                2'd0: wr(VT[k].addr, VT[k].data);
                2'd1: begin
                    rd(VT[k].addr, v);
                    chk($sformatf("R%0d table %0d", VT[k].req, k), v, VT[k].exp);
                end
                default: chk($sformatf("R%0d table %0d", VT[k].req, k),
                             key_word(int'(VT[k].addr)), VT[k].exp);
            endcase
        end
        chk("R2 hmac_en/endian", {30'b0, core_hmac_en, core_endian_swap}, 32'h3);

        // R6 process while idle
        wr(5'h01, 32'h2);
        rd(5'h03, v); chk("R6 proc idle err", v, 32'h3);
        rd(5'h02, v); chk("R6 stays idle", v, 32'h10);
        rd(5'h04, v); chk("R11 err flag", v, 32'h4);
        wr(5'h04, 32'h4);
        rd(5'h04, v); chk("R11 w1c err", v, 32'h0);

        // R5 start
        wr(5'h01, 32'h1);
        chk("R5 start pulse", {31'b0, core_start}, 32'h1);
        @(negedge clk);
        chk("R5 start single", {31'b0, core_start}, 32'h0);
        rd(5'h02, v); chk("R5 absorb", v, 32'h11);

        // R3 config write while busy
        wr(5'h00, 32'h0);
        rd(5'h00, v); chk("R3 cfg kept", v, 32'hF);
        rd(5'h03, v); chk("R3 no err", v, 32'h3);

        // R4 key write while busy
        wr(5'h08, 32'hDEAD_BEEF);
        chk("R4 key kept", key_word(0), 32'hCAFE_0000);
        rd(5'h03, v); chk("R4 key err", v, 32'h1);
        chk("R4 err intr", {31'b0, intr_err}, 32'h1);

        // R7 start while busy
        wr(5'h01, 32'h1);
        rd(5'h03, v); chk("R7 start busy err", v, 32'h2);

        // R11 fifo edge coincides with clear
        @(negedge clk); fifo_empty = 1'b0;
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 5'h04; reg_wdata = 32'h7; fifo_empty = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
        rd(5'h04, v); chk("R11 set wins", v, 32'h2);

        // R8 done outside FINISH ignored
        @(negedge clk); core_done = 1'b1; core_digest = '1;
        @(negedge clk); core_done = 1'b0;
        rd(5'h02, v); chk("R8 stray done", v, 32'h11);

        // R6 process
        wr(5'h01, 32'h2);
        chk("R6 proc pulse", {31'b0, core_process}, 32'h1);
        rd(5'h02, v); chk("R6 finish", v, 32'h12);

        // R8 completion
        @(negedge clk);
        core_done = 1'b1;
        for (int i = 0; i < 8; i++) core_digest[255-32*i -: 32] = dword(i);
        @(negedge clk); core_done = 1'b0; core_digest = '0;
        chk("R8 done intr", {31'b0, intr_done}, 32'h1);
        rd(5'h02, v); chk("R8 back idle", v, 32'h10);

        // R9 digest readout
        rd(5'h10, v); chk("R9 swap w0", v, swp(dword(0)));
        rd(5'h17, v); chk("R9 swap w7", v, swp(dword(7)));
        wr(5'h00, 32'h2);
        rd(5'h10, v); chk("R9 plain w0", v, dword(0));
        rd(5'h13, v); chk("R9 plain w3", v, dword(3));
        rd(5'h17, v); chk("R9 plain w7", v, dword(7));

        // R11 clear done only
        wr(5'h04, 32'h1);
        rd(5'h04, v); chk("R11 w1c done", v, 32'h2);

        // R10 digest cleared by disabling SHA
        wr(5'h00, 32'h0);
        rd(5'h10, v); chk("R10 digest cleared", v, 32'h0);

        // R7 start with SHA disabled
        wr(5'h01, 32'h1);
        chk("R7 no pulse", {31'b0, core_start}, 32'h0);
        rd(5'h03, v); chk("R7 start off err", v, 32'h4);
        rd(5'h02, v); chk("R7 stays idle", v, 32'h10);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule